// File: doc/BRIEF.md
# Gated Performance Cycle Counter

This block is a small performance counter unit that sits behind a processor's control and status register port. It holds three registers: a 32-bit cycle counter, an event enable mask and a global mode register. Software reads and writes each register through a simple port made of an address, write data, a write strobe and combinational read data.

The counter is off after reset. It advances by one on every clock only while two separate enables are set: bit 0 of the event mask and bit 0 of the mode register. Bit 1 of the mode register chooses what happens at the top of the range. When it is clear, the counter wraps to zero, so an unsigned difference between two reads stays correct across one wrap. When it is set, the counter stops at the all-ones value. Software may also load the counter directly.

Top module: `perf_cycle_unit`

## Requirements
- R1: After reset the counter, the event mask and the mode register all read as zero, and the counter stays at zero until it is enabled.
- R2: The counter is at address 0x780, the event mask at 0x7A0 and the mode register at 0x7A1. Only mask bit 0 (cycle enable) is stored, along with mode bits 1:0 (bit 0 run, bit 1 saturate). Every other bit of these registers reads as zero.
- R3: The counter holds its value unless mask bit 0 and mode bit 0 are both 1.
- R4: While both enables are set, the counter rises by exactly one on each clock edge. An enable written at one edge takes effect from the next edge.
- R5: With mode bit 1 clear, an enabled counter at 0xFFFFFFFF goes to 0 on the next edge.
- R6: With mode bit 1 set, an enabled counter at 0xFFFFFFFF stays at 0xFFFFFFFF.
- R7: A write to address 0x780 loads the write data into the counter at that edge. It takes priority over any increment in the same cycle.
- R8: A read of any other address returns zero, and a write to any other address changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address for read and write |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write strobe, sampled at the rising clock edge |
| csr_rdata | output | 32 | Combinational read data for csr_addr |

## Verification
On every cycle, the assertions check the one-step increment, wrapping at the top, saturating at the top, holding while either enable is clear, the priority of a counter load, and zero read data for unmapped addresses. Some behaviours can only be shown by the bench's scenarios. These are the reset values, the read-back masking of unimplemented register bits, and the cycle at which a newly written enable starts counting. They also include the unsigned difference across a wrap and the fact that writes to a full sweep of unmapped addresses leave all three registers unchanged. The bench covers every combination of mask and mode, and a range of counting lengths.

// File: rtl/perf_cycle_pkg.sv
package perf_cycle_pkg;

    // Bit positions decoded by software; behaviour depends on them.
    localparam int unsigned EVT_CYCLE_BIT = 0;
    localparam int unsigned MODE_RUN_BIT  = 0;
    localparam int unsigned MODE_SAT_BIT  = 1;
    localparam int unsigned MODE_W        = 2;

    typedef struct packed {
        logic sat;   // bit 1: hold at maximum instead of wrapping
        logic run;   // bit 0: global enable
    } pcu_mode_t;

    typedef struct packed {
        logic hit_cnt;
        logic hit_evt;
        logic hit_mode;
    } pcu_sel_t;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import perf_cycle_pkg::*;
#(
    parameter int unsigned            ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]      ADDR_CNT  = 12'h780,
    parameter logic [ADDR_W-1:0]      ADDR_EVT  = 12'h7A0,
    parameter logic [ADDR_W-1:0]      ADDR_MODE = 12'h7A1
) (
    input  logic [ADDR_W-1:0] addr,
    output pcu_sel_t          sel
);

    always_comb begin
        sel          = '0;
        sel.hit_cnt  = (addr == ADDR_CNT);
        sel.hit_evt  = (addr == ADDR_EVT);
        sel.hit_mode = (addr == ADDR_MODE);
    end

endmodule

// File: rtl/pcu_count.sv
module pcu_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             inc_en,
    input  logic             sat_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] nxt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_top;

    assign at_top = (cur == CNT_TOP);

    always_comb begin
        if (load) begin
            nxt = load_val;
        end else if (!inc_en) begin
            nxt = cur;
        end else if (sat_en && at_top) begin
            nxt = cur;
        end else begin
            nxt = cur + CNT_ONE;
        end
    end

endmodule

// File: rtl/pcu_rdmux.sv
module pcu_rdmux
    import perf_cycle_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned EVT_W  = 1
) (
    input  pcu_sel_t           sel,
    input  logic [DATA_W-1:0]  cnt,
    input  logic [EVT_W-1:0]   evt,
    input  pcu_mode_t          mode,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] evt_ext;
    logic [DATA_W-1:0] mode_ext;

    generate
        if (EVT_W < DATA_W) begin : g_evt_pad
            assign evt_ext = {{(DATA_W-EVT_W){1'b0}}, evt};
        end else begin : g_evt_full
            assign evt_ext = evt[DATA_W-1:0];
        end
    endgenerate

    assign mode_ext = {{(DATA_W-MODE_W){1'b0}}, mode};

    always_comb begin
        rdata = '0;
        if (sel.hit_cnt) begin
            rdata = cnt;
        end else if (sel.hit_evt) begin
            rdata = evt_ext;
        end else if (sel.hit_mode) begin
            rdata = mode_ext;
        end
    end

endmodule

// File: rtl/perf_cycle_unit.sv
module perf_cycle_unit
    import perf_cycle_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 12,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       EVT_W     = 1,
    parameter logic [ADDR_W-1:0] ADDR_CNT  = 12'h780,
    parameter logic [ADDR_W-1:0] ADDR_EVT  = 12'h7A0,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 12'h7A1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              csr_we,
    output logic [DATA_W-1:0] csr_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [EVT_W-1:0]  evt;
        pcu_mode_t         mode;
    } pcu_state_t;

    pcu_state_t        state_d;
    pcu_state_t        state_q;
    pcu_sel_t          sel;
    logic [DATA_W-1:0] cnt_nxt;
    logic              inc_en;
    logic              load_cnt;

    // Observation points for the bound checker.
    logic [DATA_W-1:0] cnt_q;
    logic              count_on;
    logic              sat_on;

    pcu_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_CNT (ADDR_CNT),
        .ADDR_EVT (ADDR_EVT),
        .ADDR_MODE(ADDR_MODE)
    ) decode_i (
        .addr(csr_addr),
        .sel (sel)
    );

    assign inc_en   = state_q.evt[EVT_CYCLE_BIT] & state_q.mode.run;
    assign load_cnt = csr_we & sel.hit_cnt;

    pcu_count #(
        .CNT_W(DATA_W)
    ) count_i (
        .cur     (state_q.cnt),
        .inc_en  (inc_en),
        .sat_en  (state_q.mode.sat),
        .load    (load_cnt),
        .load_val(csr_wdata),
        .nxt     (cnt_nxt)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_nxt;
        if (csr_we && sel.hit_evt) begin
            state_d.evt = csr_wdata[EVT_W-1:0];
        end
        if (csr_we && sel.hit_mode) begin
            state_d.mode.run = csr_wdata[MODE_RUN_BIT];
            state_d.mode.sat = csr_wdata[MODE_SAT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    pcu_rdmux #(
        .DATA_W(DATA_W),
        .EVT_W (EVT_W)
    ) rdmux_i (
        .sel  (sel),
        .cnt  (state_q.cnt),
        .evt  (state_q.evt),
        .mode (state_q.mode),
        .rdata(csr_rdata)
    );

    assign cnt_q    = state_q.cnt;
    assign count_on = state_q.evt[EVT_CYCLE_BIT] & state_q.mode.run;
    assign sat_on   = state_q.mode.sat;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int unsigned       ADDR_W    = 12,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_CNT  = 12'h780,
    parameter logic [ADDR_W-1:0] ADDR_EVT  = 12'h7A0,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 12'h7A1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [DATA_W-1:0] csr_wdata,
    input logic              csr_we,
    input logic [DATA_W-1:0] csr_rdata,
    input logic [DATA_W-1:0] cnt_q,
    input logic              count_on,
    input logic              sat_on
);

    localparam logic [DATA_W-1:0] TOP = '1;

    logic wr_cnt;
    logic unmapped;

    assign wr_cnt   = csr_we && (csr_addr == ADDR_CNT);
    assign unmapped = (csr_addr != ADDR_CNT) && (csr_addr != ADDR_EVT) &&
                      (csr_addr != ADDR_MODE);

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_on && !wr_cnt) |=> $stable(cnt_q));

    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_on && !wr_cnt && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_wrap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_on && !sat_on && !wr_cnt && cnt_q == TOP) |=> (cnt_q == '0));

    p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_on && sat_on && !wr_cnt && cnt_q == TOP) |=> (cnt_q == TOP));

    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(csr_wdata)));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (csr_rdata == '0));

endmodule

bind perf_cycle_unit pcu_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADDR_CNT (ADDR_CNT),
    .ADDR_EVT (ADDR_EVT),
    .ADDR_MODE(ADDR_MODE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_addr (csr_addr),
    .csr_wdata(csr_wdata),
    .csr_we   (csr_we),
    .csr_rdata(csr_rdata),
    .cnt_q    (cnt_q),
    .count_on (count_on),
    .sat_on   (sat_on)
);

// File: tb/perf_cycle_unit_tb_top.sv
`timescale 1ns/1ps
module perf_cycle_unit_tb_top;

    localparam logic [11:0] A_CNT  = 12'h780;
    localparam logic [11:0] A_EVT  = 12'h7A0;
    localparam logic [11:0] A_MODE = 12'h7A1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    perf_cycle_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .csr_we   (csr_we),
        .csr_rdata(csr_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Write spans exactly one rising edge; returns at the following falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_we    = 1'b1;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        csr_we   = 1'b0;
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and no counting while disabled
        rd(A_CNT, v);  check("R1 counter", v, 32'h0);
        rd(A_EVT, v);  check("R1 mask", v, 32'h0);
        rd(A_MODE, v); check("R1 mode", v, 32'h0);
        idle(10);
        rd(A_CNT, v);  check("R1 counter idle", v, 32'h0);

        // R2: field masking on read-back
        wr(A_EVT, 32'hFFFF_FFFF);  rd(A_EVT, v);  check("R2 mask bits", v, 32'h1);
        wr(A_MODE, 32'hFFFF_FFFE); rd(A_MODE, v); check("R2 mode bits", v, 32'h2);
        wr(A_MODE, 32'h0);         rd(A_MODE, v); check("R2 mode clear", v, 32'h0);
        wr(A_EVT, 32'h0);          rd(A_EVT, v);  check("R2 mask clear", v, 32'h0);

        // R3: all mask/mode combinations
        for (int m = 0; m < 2; m++) begin
            for (int md = 0; md < 4; md++) begin
                wr(A_EVT, m);
                wr(A_MODE, md);
                wr(A_CNT, 32'd1000);
                idle(9);
                rd(A_CNT, v);
                check("R3 gate", v, 32'd1000 + (((m & md) & 1) ? 32'd9 : 32'd0));
            end
        end

        // R4: exact count over many lengths
        wr(A_EVT, 32'h1);
        wr(A_MODE, 32'h1);
        for (int n = 0; n < 40; n++) begin
            wr(A_CNT, 32'd5000 + n);
            idle(n);
            rd(A_CNT, v);
            check("R4 length", v, 32'd5000 + n + n);
        end
        // R4: enable takes effect from the edge after its write
        wr(A_MODE, 32'h0);
        wr(A_CNT, 32'd77);
        wr(A_MODE, 32'h1);
        rd(A_CNT, v); check("R4 enable latency", v, 32'd77);
        idle(1);
        rd(A_CNT, v); check("R4 first step", v, 32'd78);

        // R5: wrap and unsigned difference
        wr(A_CNT, 32'hFFFF_FFFD);
        idle(1);
        rd(A_CNT, a); check("R5 before wrap", a, 32'hFFFF_FFFE);
        idle(4);
        rd(A_CNT, b); check("R5 after wrap", b, 32'h2);
        check("R5 difference", b - a, 32'd4);

        // R6: saturation, then release
        wr(A_MODE, 32'h3);
        wr(A_CNT, 32'hFFFF_FFFD);
        idle(5);
        rd(A_CNT, v); check("R6 saturate", v, 32'hFFFF_FFFF);
        idle(3);
        rd(A_CNT, v); check("R6 hold", v, 32'hFFFF_FFFF);
        wr(A_MODE, 32'h1);
        rd(A_CNT, v); check("R6 release edge", v, 32'hFFFF_FFFF);
        idle(1);
        rd(A_CNT, v); check("R5 wrap after release", v, 32'h0);

        // R7: load wins over increment
        wr(A_CNT, 32'h55);
        rd(A_CNT, v); check("R7 load priority", v, 32'h55);
        wr(A_MODE, 32'h3);
        wr(A_CNT, 32'hFFFF_FFFF);
        rd(A_CNT, v); check("R7 load at top", v, 32'hFFFF_FFFF);
        wr(A_CNT, 32'h10);
        rd(A_CNT, v); check("R7 load while saturating", v, 32'h10);

        // R8: unmapped sweep, counter stopped and nonzero
        wr(A_MODE, 32'h2);
        wr(A_CNT, 32'h1234_5678);
        for (int ad = 12'h700; ad < 12'h800; ad++) begin
            if (ad == A_CNT || ad == A_EVT || ad == A_MODE) continue;
            rd(ad[11:0], v);
            check("R8 read zero", v, 32'h0);
            wr(ad[11:0], 32'hFFFF_FFFF);
        end
        rd(12'h000, v); check("R8 read low", v, 32'h0);
        wr(12'hFFF, 32'hFFFF_FFFF);
        rd(A_CNT, v);  check("R8 counter kept", v, 32'h1234_5678);
        rd(A_EVT, v);  check("R8 mask kept", v, 32'h1);
        rd(A_MODE, v); check("R8 mode kept", v, 32'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule